// File: doc/BRIEF.md
# Lane-wise Signed Compare-Against-Zero Unit

This block takes one 128-bit packed operand and tests every signed element in it against zero. An element holding zero or a positive value is replaced by all ones. An element whose two's-complement value is negative is replaced by all zeros. The output is therefore a per-lane mask that later select or blend logic can use directly.

The element width comes from a 2-bit size code and equals 8 shifted left by that code. The active data width comes from a form flag and a width selector. The vector form uses 64 bits or 128 bits. The scalar form uses a single 64-bit element. Any encoding that is not legal is flagged as undefined.

An operation is accepted on a clock edge where `in_valid` is high, and its result appears exactly one cycle later. That latency is the same whatever the data values are.

Top module: `simd_cmpz`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `out_valid`, `out_undef` and `out_result` all zero.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low after an edge where it was low; this one-cycle latency never depends on operand values.
- R3: In the vector form (`in_scalar`=0), elements are 8, 16, 32 or 64 bits wide for `in_size` 00, 01, 10 and 11. Element e occupies bits [e*W+W-1 : e*W], and its top bit is the sign. Each element becomes all ones when its sign bit is 0 and all zeros when its sign bit is 1.
- R4: An element equal to zero yields all ones, and an element equal to the most negative value yields all zeros.
- R5: In the vector form with `in_q`=0, only bits 63:0 are processed and bits 127:64 of `out_result` are zero. With `in_q`=1, all 128 bits are processed.
- R6: The vector form with `in_size`=11 and `in_q`=0 sets `out_undef` together with `out_valid`, and `out_result` is zero.
- R7: In the scalar form (`in_scalar`=1), `in_size`=11 processes one 64-bit element in bits 63:0 and ignores `in_q`; bits 127:64 of the result are zero. Any other `in_size` sets `out_undef`, and the result is zero.
- R8: After an edge where `in_valid` was low, `out_result` keeps its previous value and `out_undef` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_scalar | input | 1 | 1 = scalar form, 0 = vector form |
| in_size | input | 2 | Element size code (width = 8 << code) |
| in_q | input | 1 | Vector width select: 0 = 64 bits, 1 = 128 bits |
| in_src | input | 128 | Packed source operand |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_undef | output | 1 | Accepted encoding was undefined |
| out_result | output | 128 | Per-lane all-ones / all-zeros mask |

## Verification
All sixteen combinations of form, size and width select are swept. Each combination is tried with these operands: all zeros, all ones, alternating minimum and maximum lane values, and pseudo-random words. Zero and all-ones separate the greater-or-equal condition from a strict greater-than condition. Alternating per-byte sign patterns show whether the lane width was decoded correctly, because a wrong width picks up the wrong sign bit. Random words in the 64-bit modes expose leakage into the upper half. Idle cycles with changing data, placed after both legal and undefined operations, check that the result is held.

// File: rtl/simd_cmpz_pkg.sv
package simd_cmpz_pkg;

    localparam int unsigned CMPZ_DATA_W   = 128;
    localparam int unsigned CMPZ_LANE_MIN = 8;
    localparam int unsigned CMPZ_NSIZES   = 4;
    localparam int unsigned CMPZ_SIZE_W   = $clog2(CMPZ_NSIZES);

    // size code whose element equals the full half-width (64 bits)
    localparam logic [CMPZ_SIZE_W-1:0] CMPZ_SIZE_DWORD = CMPZ_SIZE_W'(CMPZ_NSIZES - 1);

    typedef struct packed {
        logic                   undef;  // encoding not legal
        logic [CMPZ_SIZE_W-1:0] esel;   // element width selector
        logic                   full;   // 1: whole register active, 0: lower half
    } cmpz_dec_t;

endpackage

// File: rtl/simd_cmpz_decode.sv
module simd_cmpz_decode
    import simd_cmpz_pkg::*;
(
    input  logic                   scalar,
    input  logic [CMPZ_SIZE_W-1:0] size,
    input  logic                   q,
    output cmpz_dec_t              dec
);

    logic size_is_dword;

    always_comb begin
        size_is_dword = (size == CMPZ_SIZE_DWORD);
        dec       = '0;
        dec.esel  = size;
        if (scalar) begin
            // scalar form: one element of the half width, only the widest size
            dec.undef = !size_is_dword;
            dec.full  = 1'b0;
        end else begin
            // vector form: widest size needs the full register
            dec.undef = size_is_dword && !q;
            dec.full  = q;
        end
    end

endmodule

// File: rtl/simd_cmpz_lanes.sv
module simd_cmpz_lanes
    import simd_cmpz_pkg::*;
#(
    parameter int unsigned DATA_W   = CMPZ_DATA_W,
    parameter int unsigned LANE_MIN = CMPZ_LANE_MIN,
    parameter int unsigned NSIZES   = CMPZ_NSIZES,
    localparam int unsigned SEL_W   = $clog2(NSIZES)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SEL_W-1:0]  esel,
    output logic [DATA_W-1:0] mask
);

    logic [NSIZES-1:0][DATA_W-1:0] cand;

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int unsigned W = LANE_MIN << g;
        localparam int unsigned N = DATA_W / W;
        for (genvar l = 0; l < N; l++) begin : g_lane
            // non-negative when the sign bit is clear
            assign cand[g][l*W +: W] = {W{~src[l*W + W - 1]}};
        end
    end

    assign mask = cand[esel];

endmodule

// File: rtl/simd_cmpz_clip.sv
module simd_cmpz_clip
    import simd_cmpz_pkg::*;
#(
    parameter int unsigned DATA_W = CMPZ_DATA_W,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] mask_in,
    input  logic              full,
    input  logic              undef,
    output logic [DATA_W-1:0] mask_out
);

    logic [DATA_W-1:0] keep;

    always_comb begin
        keep = full ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        mask_out = undef ? '0 : (mask_in & keep);
    end

endmodule

// File: rtl/simd_cmpz.sv
module simd_cmpz
    import simd_cmpz_pkg::*;
#(
    parameter int unsigned DATA_W   = CMPZ_DATA_W,
    parameter int unsigned LANE_MIN = CMPZ_LANE_MIN
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_scalar,
    input  logic [CMPZ_SIZE_W-1:0] in_size,
    input  logic                   in_q,
    input  logic [DATA_W-1:0]      in_src,
    output logic                   out_valid,
    output logic                   out_undef,
    output logic [DATA_W-1:0]      out_result
);

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic [DATA_W-1:0] result;
    } state_t;

    state_t            state_d, state_q;
    cmpz_dec_t         dec;
    logic [DATA_W-1:0] raw_mask;
    logic [DATA_W-1:0] clip_mask;

    simd_cmpz_decode i_decode (
        .scalar (in_scalar),
        .size   (in_size),
        .q      (in_q),
        .dec    (dec)
    );

    simd_cmpz_lanes #(
        .DATA_W   (DATA_W),
        .LANE_MIN (LANE_MIN),
        .NSIZES   (CMPZ_NSIZES)
    ) i_lanes (
        .src  (in_src),
        .esel (dec.esel),
        .mask (raw_mask)
    );

    simd_cmpz_clip #(
        .DATA_W (DATA_W)
    ) i_clip (
        .mask_in  (raw_mask),
        .full     (dec.full),
        .undef    (dec.undef),
        .mask_out (clip_mask)
    );

    always_comb begin
        state_d        = state_q;
        state_d.valid  = in_valid;
        state_d.undef  = 1'b0;
        if (in_valid) begin
            state_d.undef  = dec.undef;
            state_d.result = clip_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign out_undef  = state_q.undef;
    assign out_result = state_q.result;

endmodule

// File: rtl/simd_cmpz_chk.sv
module simd_cmpz_chk
    import simd_cmpz_pkg::*;
#(
    parameter int unsigned DATA_W = CMPZ_DATA_W,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_scalar,
    input logic [CMPZ_SIZE_W-1:0] in_size,
    input logic                   in_q,
    input logic [DATA_W-1:0]      in_src,
    input logic                   out_valid,
    input logic                   out_undef,
    input logic [DATA_W-1:0]      out_result
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_undef && out_result == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r4_zero_vector_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_scalar && in_q && in_src == '0) |=> (out_result == {DATA_W{1'b1}}));

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_q) |=> (out_result[DATA_W-1:HALF_W] == '0));

    a_r6_vec_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_scalar && in_size == CMPZ_SIZE_DWORD && !in_q) |=> (out_undef && out_valid));

    a_r6_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (out_result == '0 && out_valid));

    a_r7_scalar_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_scalar && in_size != CMPZ_SIZE_DWORD) |=> out_undef);

    a_r7_scalar_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_scalar) |=> (out_result[DATA_W-1:HALF_W] == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(out_result) && !out_undef));

endmodule

bind simd_cmpz simd_cmpz_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_scalar  (in_scalar),
    .in_size    (in_size),
    .in_q       (in_q),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_undef  (out_undef),
    .out_result (out_result)
);

// File: tb/test_simd_cmpz.sv
module test_simd_cmpz;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_scalar;
    logic [1:0]   in_size;
    logic         in_q;
    logic [127:0] in_src;
    logic         out_valid;
    logic         out_undef;
    logic [127:0] out_result;

    int total = 0;
    int bad   = 0;
    logic [127:0] last_exp;
    logic [31:0]  seed = 32'h1234_5678;

    always #10 clk = ~clk;  // 50 MHz

    simd_cmpz i_simd_cmpz (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_scalar  (in_scalar),
        .in_size    (in_size),
        .in_q       (in_q),
        .in_src     (in_src),
        .out_valid  (out_valid),
        .out_undef  (out_undef),
        .out_result (out_result)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // model: returns {undef, result}
    function automatic logic [128:0] model(input logic sc, input logic [1:0] sz,
                                           input logic q, input logic [127:0] src);
        int w;
        int dw;
        logic u;
        logic [127:0] r;
        w  = 8 << sz;
        dw = sc ? 64 : (q ? 128 : 64);
        u  = sc ? (sz != 2'd3) : (sz == 2'd3 && !q);
        r  = '0;
        if (!u) begin
            for (int i = 0; i < 128; i++) begin
                if (i < dw) begin
                    int lane;
                    lane = i / w;
                    r[i] = ~src[lane * w + w - 1];
                end
            end
        end
        return {u, r};
    endfunction

    task automatic run_op(input logic sc, input logic [1:0] sz, input logic q,
                          input logic [127:0] src, input string req);
        logic [128:0] m;
        in_valid  = 1'b1;
        in_scalar = sc;
        in_size   = sz;
        in_q      = q;
        in_src    = src;
        m = model(sc, sz, q, src);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {127'd0, out_valid}, 128'd1);
        check({req, " undef"}, {127'd0, out_undef}, {127'd0, m[128]});
        check({req, " result"}, out_result, m[127:0]);
        last_exp = m[127:0];
    endtask

    task automatic idle_check(input string req);
        seed = next_rand(seed);
        in_valid = 1'b0;
        in_src   = {4{seed}};
        in_size  = seed[1:0];
        in_q     = seed[2];
        @(negedge clk);
        check({req, " idle valid"}, {127'd0, out_valid}, 128'd0);
        check({req, " idle undef"}, {127'd0, out_undef}, 128'd0);
        check({req, " idle hold"}, out_result, last_exp);
    endtask

    initial begin
        #5_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_scalar = 1'b0;
        in_size = 2'd0;
        in_q = 1'b1;
        in_src = '0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset overrides a pending valid operation
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 undef", {127'd0, out_undef}, 128'd0);
        check("R1 result", out_result, 128'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {127'd0, out_valid}, 128'd0);

        for (int c = 0; c < 16; c++) begin
            logic sc;
            logic [1:0] sz;
            logic q;
            string tag;
            sc = c[3];
            sz = c[2:1];
            q  = c[0];
            if (sc) tag = (sz == 2'd3) ? "R7" : "R7 undef";
            else if (sz == 2'd3 && !q) tag = "R6";
            else if (!q) tag = "R5";
            else tag = "R3";
            run_op(sc, sz, q, 128'd0, {tag, " R4 zero"});
            run_op(sc, sz, q, {128{1'b1}}, {tag, " all-ones"});
            run_op(sc, sz, q, {16{8'h80}}, {tag, " R4 min bytes"});
            run_op(sc, sz, q, {8{8'h7F, 8'h80}}, {tag, " alt bytes"});
            run_op(sc, sz, q, {8{16'h8000}}, {tag, " R4 min half"});
            run_op(sc, sz, q, {4{32'h8000_0000}}, {tag, " min word"});
            run_op(sc, sz, q, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, {tag, " dword"});
            for (int k = 0; k < 4; k++) begin
                logic [127:0] r;
                seed = next_rand(seed); r[31:0]   = seed;
                seed = next_rand(seed); r[63:32]  = seed;
                seed = next_rand(seed); r[95:64]  = seed;
                seed = next_rand(seed); r[127:96] = seed;
                run_op(sc, sz, q, r, {tag, " R2 random"});
            end
            idle_check("R8");
        end

        // back-to-back operations, then hold after undefined
        run_op(1'b0, 2'd0, 1'b1, {8{16'h00FF}}, "R3 b2b first");
        run_op(1'b0, 2'd1, 1'b1, {8{16'h00FF}}, "R3 b2b second");
        run_op(1'b0, 2'd3, 1'b0, {128{1'b0}}, "R6 then idle");
        idle_check("R8 after undef");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule